// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block is a synchronous state machine that holds the operating mode of a microcontroller. It moves the mode among high-speed, subactive, subsleep, watch and hardware-standby. The CPU issues a one-cycle sleep strobe. At that moment four control bits decide where the mode goes: standby-select, direct-transition enable, low-speed-on and a watchdog subclock-source select. An interrupt request wakes the block from the two subclock-idle modes. Two active-low board pins, the standby pin and the reset pin, override everything else.

From the registered mode the block drives three things: a subclock select for the system clock, a CPU run enable, and one clock enable per peripheral module. It also raises an error flag when the system-clock divider select is nonzero while the CPU is running on the subclock. A sleep strobe whose control bits match no defined transition leaves the mode unchanged. It raises an illegal-transition flag for one cycle.

Top module: `lpm_ctrl`

## Requirements
- R1: The mode code is 0 for high-speed, 1 for subactive, 2 for subsleep, 3 for watch, 4 for hardware-standby and 5 for the reset-wait state. When the reset pin is low, the standby pin is high and the mode is neither 4 nor 5, the mode becomes high-speed after the next clock edge. Reset also takes priority over a sleep strobe or an interrupt in the same cycle.
- R2: In high-speed mode, a sleep strobe with standby-select=1, direct=1 and subclock-source=1 moves the mode to subactive.
- R3: In subactive mode, a sleep strobe with standby-select=1, direct=0 and subclock-source=1 moves the mode to watch.
- R4: In subactive mode, a sleep strobe with standby-select=0, low-speed-on=1 and subclock-source=1 moves the mode to subsleep.
- R5: In subactive mode, a sleep strobe with standby-select=1, direct=1, low-speed-on=0 and subclock-source=1 moves the mode straight to high-speed.
- R6: In high-speed or subactive mode, a sleep strobe with any other bit combination keeps the mode. The illegal flag is then high for exactly the cycle after that edge.
- R7: In watch mode, an interrupt moves the mode to subactive when low-speed-on=1 and has no effect when low-speed-on=0.
- R8: In subsleep mode, any interrupt moves the mode to subactive.
- R9: A low standby pin moves the mode to hardware-standby after the next edge, from any state and regardless of the reset pin.
- R10: In hardware-standby, the mode stays put while the reset pin is high. With the standby pin high and the reset pin low, the mode goes to reset-wait (5) and stays there while reset stays low. On the first edge with reset high it goes to high-speed.
- R11: The subclock select is 1 in modes 1, 2 and 3, and the CPU run enable is 1 in modes 0 and 1. With 8 modules, the enables are:
  - all 1 in high-speed;
  - bits 0 to 3 only (the two timers and the two watchdogs) in subactive and subsleep;
  - bit 3 only in watch;
  - none in modes 4 and 5.
- R12: The divider error output is 1 exactly when the mode is subactive and the divider select is nonzero.
- R13: A sleep strobe in subsleep, watch, hardware-standby or reset-wait, and an interrupt in high-speed or subactive, change no output and do not raise the illegal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Active-low reset pin, sampled synchronously |
| stby_pin_n | input | 1 | Active-low hardware-standby pin, highest priority |
| sleep_req | input | 1 | One-cycle sleep-instruction strobe |
| irq | input | 1 | Interrupt request |
| stby_sel | input | 1 | Standby-select control bit |
| direct_en | input | 1 | Direct-transition enable bit |
| lowspd_on | input | 1 | Low-speed-on bit |
| wd_subclk | input | 1 | Watchdog subclock-source select bit |
| ckdiv_sel | input | DIV_W | System-clock divider select field |
| mode | output | 3 | Current mode code |
| clk_sub | output | 1 | 1 selects the subclock for the system clock |
| cpu_run | output | 1 | CPU clock enable |
| mod_en | output | N_MOD | Per-module clock enables |
| illegal | output | 1 | One-cycle flag for an undefined sleep combination |
| div_err | output | 1 | Divider select nonzero while subactive |

## Verification
Several properties are checked on every cycle:
- a low standby pin always leads to hardware-standby;
- a subsleep interrupt always leads to subactive;
- subactive mode never shows an enable outside the timer and watchdog bits and always runs on the subclock;
- an illegal flag always comes after a sleep strobe with the mode unchanged;
- the divider error never shows outside subactive.

Only the bench's scenarios can show that each control-bit combination reaches its own target mode. The same holds for the exit path from hardware-standby through reset-wait, and for strobes and interrupts in the wrong mode leaving every output untouched.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        M_HIGH    = 3'd0,
        M_SUBACT  = 3'd1,
        M_SUBSLP  = 3'd2,
        M_WATCH   = 3'd3,
        M_HWSTBY  = 3'd4,
        M_RSTWAIT = 3'd5
    } mode_e;

    typedef struct packed {
        logic stby_sel;
        logic direct;
        logic lowspd;
        logic wd_sub;
    } ctl_t;
endpackage

// File: rtl/lpm_next.sv
module lpm_next
    import lpm_pkg::*;
(
    input  mode_e cur,
    input  logic  sleep,
    input  logic  irq,
    input  ctl_t  ctl,
    input  logic  rst_pin_n,
    input  logic  stby_pin_n,
    output mode_e nxt,
    output logic  illegal
);
    logic go_watch, go_subslp, go_high, go_sub;

    always_comb begin
        go_sub    = ctl.stby_sel && ctl.direct && ctl.wd_sub;
        go_watch  = ctl.wd_sub && ctl.stby_sel && !ctl.direct;
        go_subslp = ctl.wd_sub && !ctl.stby_sel && ctl.lowspd;
        go_high   = ctl.wd_sub && ctl.stby_sel && ctl.direct && !ctl.lowspd;
    end

    always_comb begin
        nxt     = cur;
        illegal = 1'b0;
        if (!stby_pin_n) begin
            nxt = M_HWSTBY;
        end else if (cur == M_HWSTBY || cur == M_RSTWAIT) begin
            if (!rst_pin_n)              nxt = M_RSTWAIT;
            else if (cur == M_RSTWAIT)   nxt = M_HIGH;
        end else if (!rst_pin_n) begin
            nxt = M_HIGH;
        end else begin
            case (cur)
                M_HIGH: begin
                    if (sleep) begin
                        if (go_sub) nxt = M_SUBACT;
                        else        illegal = 1'b1;
                    end
                end
                M_SUBACT: begin
                    if (sleep) begin
                        if (go_watch)       nxt = M_WATCH;
                        else if (go_subslp) nxt = M_SUBSLP;
                        else if (go_high)   nxt = M_HIGH;
                        else                illegal = 1'b1;
                    end
                end
                M_WATCH: begin
                    if (irq && ctl.lowspd) nxt = M_SUBACT;
                end
                M_SUBSLP: begin
                    if (irq) nxt = M_SUBACT;
                end
                default: nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/lpm_gate.sv
module lpm_gate
    import lpm_pkg::*;
#(
    parameter int               N_MOD      = 8,
    parameter logic [N_MOD-1:0] KEEP_MASK  = 8'h0F,
    parameter logic [N_MOD-1:0] WATCH_MASK = 8'h08
) (
    input  mode_e             m,
    output logic              clk_sub,
    output logic              cpu_run,
    output logic [N_MOD-1:0]  en
);
    logic on_sub;

    always_comb begin
        on_sub  = (m == M_SUBACT) || (m == M_SUBSLP) || (m == M_WATCH);
        clk_sub = on_sub;
        cpu_run = (m == M_HIGH) || (m == M_SUBACT);
    end

    for (genvar i = 0; i < N_MOD; i++) begin : g_en
        always_comb begin
            case (m)
                M_HIGH:            en[i] = 1'b1;
                M_SUBACT, M_SUBSLP: en[i] = KEEP_MASK[i];
                M_WATCH:           en[i] = WATCH_MASK[i];
                default:           en[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int               N_MOD      = 8,
    parameter int               DIV_W      = 3,
    parameter logic [N_MOD-1:0] KEEP_MASK  = 8'h0F,
    parameter logic [N_MOD-1:0] WATCH_MASK = 8'h08
) (
    input  logic              clk,
    input  logic              rst_pin_n,
    input  logic              stby_pin_n,
    input  logic              sleep_req,
    input  logic              irq,
    input  logic              stby_sel,
    input  logic              direct_en,
    input  logic              lowspd_on,
    input  logic              wd_subclk,
    input  logic [DIV_W-1:0]  ckdiv_sel,
    output logic [MODE_W-1:0] mode,
    output logic              clk_sub,
    output logic              cpu_run,
    output logic [N_MOD-1:0]  mod_en,
    output logic              illegal,
    output logic              div_err
);
    typedef struct packed {
        mode_e             mode;
        logic              ill;
        logic              clk_sub;
        logic              cpu_run;
        logic [N_MOD-1:0]  en;
    } regs_t;

    regs_t r_d, r_q;
    ctl_t  ctl;
    mode_e nxt_mode;
    logic  nxt_ill;
    logic  g_sub, g_run;
    logic [N_MOD-1:0] g_en;

    assign ctl = '{stby_sel: stby_sel, direct: direct_en,
                   lowspd: lowspd_on, wd_sub: wd_subclk};

    lpm_next u_next (
        .cur        (r_q.mode),
        .sleep      (sleep_req),
        .irq        (irq),
        .ctl        (ctl),
        .rst_pin_n  (rst_pin_n),
        .stby_pin_n (stby_pin_n),
        .nxt        (nxt_mode),
        .illegal    (nxt_ill)
    );

    lpm_gate #(
        .N_MOD      (N_MOD),
        .KEEP_MASK  (KEEP_MASK),
        .WATCH_MASK (WATCH_MASK)
    ) u_gate (
        .m       (nxt_mode),
        .clk_sub (g_sub),
        .cpu_run (g_run),
        .en      (g_en)
    );

    always_comb begin
        r_d         = r_q;
        r_d.mode    = nxt_mode;
        r_d.ill     = nxt_ill;
        r_d.clk_sub = g_sub;
        r_d.cpu_run = g_run;
        r_d.en      = g_en;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign mode    = r_q.mode;
    assign clk_sub = r_q.clk_sub;
    assign cpu_run = r_q.cpu_run;
    assign mod_en  = r_q.en;
    assign illegal = r_q.ill;
    assign div_err = (r_q.mode == M_SUBACT) && (ckdiv_sel != '0);

    AST_STBY_WINS: assert property (@(posedge clk)
        disable iff (!rst_pin_n && stby_pin_n)
        !stby_pin_n |=> (mode == M_HWSTBY)) else $error("standby"); // R9

    AST_SUBSLP_WAKE: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (mode == M_SUBSLP && irq && stby_pin_n) |=> (mode == M_SUBACT)) else $error("wake"); // R8

    AST_SUB_GATING: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (mode == M_SUBACT) |-> (clk_sub && ((mod_en & ~KEEP_MASK) == '0))) else $error("gate"); // R11

    AST_ILL_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_pin_n)
        illegal |-> ($past(sleep_req) && mode == $past(mode))) else $error("ill"); // R6

    AST_DIVERR_ONLY_SUB: assert property (@(posedge clk) disable iff (!rst_pin_n)
        div_err |-> (mode == M_SUBACT)) else $error("div"); // R12
endmodule

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
    logic clk = 1'b0;
    logic rst_pin_n = 1'b0, stby_pin_n = 1'b1, sleep_req = 1'b0, irq = 1'b0;
    logic stby_sel = 1'b0, direct_en = 1'b0, lowspd_on = 1'b0, wd_subclk = 1'b0;
    logic [2:0] ckdiv_sel = 3'd0;
    logic [2:0] mode;
    logic clk_sub, cpu_run, illegal, div_err;
    logic [7:0] mod_en;

    int n_chk = 0, n_bad = 0;
    logic [2:0] mdl = 3'd0;

    always #2 clk = ~clk;

    lpm_ctrl u0 (
        .clk(clk), .rst_pin_n(rst_pin_n), .stby_pin_n(stby_pin_n),
        .sleep_req(sleep_req), .irq(irq), .stby_sel(stby_sel),
        .direct_en(direct_en), .lowspd_on(lowspd_on), .wd_subclk(wd_subclk),
        .ckdiv_sel(ckdiv_sel), .mode(mode), .clk_sub(clk_sub),
        .cpu_run(cpu_run), .mod_en(mod_en), .illegal(illegal), .div_err(div_err)
    );

    function automatic logic [3:0] model(input logic [2:0] m, input logic sl, iq,
                                         input logic s, d, l, p, rn, sn);
        logic [2:0] n = m;
        logic ill = 1'b0;
        if (!sn) n = 3'd4;
        else if (m == 3'd4 || m == 3'd5) n = !rn ? 3'd5 : (m == 3'd5 ? 3'd0 : 3'd4);
        else if (!rn) n = 3'd0;
        else if (m == 3'd0 && sl) begin
            if (s && d && p) n = 3'd1; else ill = 1'b1;
        end else if (m == 3'd1 && sl) begin
            casez ({s, d, l, p})
                4'b10?1: n = 3'd3;
                4'b0?11: n = 3'd2;
                4'b1101: n = 3'd0;
                default: ill = 1'b1;
            endcase
        end else if (m == 3'd3 && iq && l) n = 3'd1;
        else if (m == 3'd2 && iq) n = 3'd1;
        return {ill, n};
    endfunction

    function automatic logic [7:0] en_of(input logic [2:0] m);
        case (m)
            3'd0:       return 8'hFF;
            3'd1, 3'd2: return 8'h0F;
            3'd3:       return 8'h08;
            default:    return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] got, exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic step(input string tag, input logic sl, iq, s, d, l, p, rn, sn,
                        input logic [2:0] dv);
        logic [3:0] r;
        sleep_req = sl; irq = iq; stby_sel = s; direct_en = d; lowspd_on = l;
        wd_subclk = p; rst_pin_n = rn; stby_pin_n = sn; ckdiv_sel = dv;
        r = model(mdl, sl, iq, s, d, l, p, rn, sn);
        @(posedge clk);
        @(negedge clk);
        mdl = r[2:0];
        chk(tag, "mode", {5'd0, mode}, {5'd0, mdl});
        chk("R6", "illegal", {7'd0, illegal}, {7'd0, r[3]});
        chk("R11", "clk_sub", {7'd0, clk_sub}, {7'd0, (mdl >= 3'd1 && mdl <= 3'd3)});
        chk("R11", "cpu_run", {7'd0, cpu_run}, {7'd0, (mdl <= 3'd1)});
        chk("R11", "mod_en", mod_en, en_of(mdl));
        chk("R12", "div_err", {7'd0, div_err}, {7'd0, (mdl == 3'd1 && dv != 3'd0)});
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        //     tag   sl iq s d l p rn sn dv
        step("R1",  0, 0, 0,0,0,0, 0, 1, 0);   // reset state
        step("R13", 0, 1, 0,0,0,0, 1, 1, 0);   // irq in high-speed ignored
        step("R6",  1, 0, 1,1,0,0, 1, 1, 0);   // undefined combo in high-speed
        step("R2",  1, 0, 1,1,0,1, 1, 1, 3'd2);
        step("R12", 0, 0, 0,0,0,0, 1, 1, 3'd1);
        step("R13", 0, 1, 0,0,0,0, 1, 1, 0);   // irq in subactive ignored
        step("R4",  1, 0, 0,0,1,1, 1, 1, 0);
        step("R13", 1, 0, 1,1,0,1, 1, 1, 0);   // sleep in subsleep ignored
        step("R8",  0, 1, 0,0,0,0, 1, 1, 0);
        step("R3",  1, 0, 1,0,0,1, 1, 1, 0);
        step("R13", 1, 0, 1,1,0,1, 1, 1, 0);   // sleep in watch ignored
        step("R7",  0, 1, 0,0,0,0, 1, 1, 0);   // low-speed-on clear: stays
        step("R7",  0, 1, 0,0,1,0, 1, 1, 0);
        step("R6",  1, 0, 1,1,1,1, 1, 1, 0);   // direct with low-speed-on set
        step("R6",  1, 0, 1,0,0,0, 1, 1, 0);   // subclock source clear
        step("R5",  1, 0, 1,1,0,1, 1, 1, 0);
        step("R2",  1, 0, 1,1,0,1, 1, 1, 0);
        step("R1",  1, 1, 1,0,0,1, 0, 1, 0);   // reset beats sleep
        step("R9",  0, 0, 0,0,0,0, 0, 0, 0);   // standby beats reset
        step("R10", 0, 0, 0,0,0,0, 1, 1, 0);   // stays in standby
        step("R10", 0, 0, 0,0,0,0, 0, 1, 0);
        step("R10", 0, 0, 0,0,0,0, 0, 1, 0);
        step("R10", 0, 1, 0,0,0,0, 1, 1, 0);
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] v = $urandom;
            step("R1", (v[1:0] == 2'd0), (v[3:2] == 2'd0), v[4], v[5], v[6],
                 (v[8:7] != 2'd0), (v[14:9] != 6'd0), (v[20:15] != 6'd0),
                 (v[23:21] == 3'd7) ? 3'd0 : v[26:24]);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule